// File: doc/BRIEF.md
# Tagged Integer Add/Subtract Unit

This block adds or subtracts two 32-bit operands whose two lowest bits act as a type tag, and both must be zero for a well-formed tagged integer. Each operation is checked for two faults: a nonzero tag in either operand, and signed overflow of the arithmetic. The unit produces the result and four condition flags: negative, zero, overflow and carry.

Each operation carries a per-operation trap-enable bit. When the bit is set and a fault is found, the unit raises a one-cycle trap pulse. The result register and the flags then keep their previous contents, so nothing is committed. When the bit is clear, a fault only sets the overflow flag, and the result and the flags are written as normal. Operands are captured on an input strobe, and every output comes from a register that updates on the next clock edge.

Top module: `tagged_arith_unit`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid, trap, result and all four flags go to 0.
- R2: With op_sub=0, an accepted operation gives result = src_a + src_b modulo 2^32, with out_valid high in the cycle after in_valid.
- R3: With op_sub=1, an accepted operation gives result = src_a - src_b modulo 2^32, with the same one-cycle latency.
- R4: On a written result, flag_n equals bit 31 of the result and flag_z is 1 exactly when the result is zero.
- R5: On a written result, flag_c is the carry out of bit 31 for an add, and for a subtract it is 1 exactly when src_a is less than src_b as unsigned values.
- R6: A tag fault exists when bit 0 or bit 1 of either source operand is 1.
- R7: Arithmetic overflow exists for an add when both sources have the same bit 31 and the result's bit 31 differs from src_a. For a subtract it exists when the sources differ in bit 31 and the result's bit 31 differs from src_a.
- R8: With trap_en=1 and a tag fault or overflow, trap is high for exactly the next cycle, out_valid stays low, and result and the flags keep their prior values.
- R9: With trap_en=0, a tag fault or overflow sets flag_v to 1 while the result is written and out_valid is asserted. With no fault, flag_v is 0.
- R10: In a cycle after in_valid was low, out_valid and trap are low, and result and the flags hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe; operands sampled when high |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| trap_en | input | 1 | 1 = faults trap; 0 = faults only set flag_v |
| src_a | input | 32 | First operand (minuend) |
| src_b | input | 32 | Second operand (subtrahend) |
| out_valid | output | 1 | Result and flags written this cycle |
| result | output | 32 | Registered sum or difference |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow or tag-fault flag |
| flag_c | output | 1 | Carry (add) or borrow (subtract) |
| trap | output | 1 | One-cycle tag-overflow trap pulse |

## Verification
The operations tried are clean adds and subtracts, adds that carry out or cross the signed limit, subtracts that borrow or overflow in either direction, and results of exactly zero. Each of these separates one flag's logic from the others. Tag faults are placed in operand A and in operand B alone, so the tag test is seen to examine both sources. Each fault and each overflow is run twice, once with trapping enabled and once without. The trapping run shows that the result and the flags hold their prior values. The other run shows flag_v set while the result is still written. Idle cycles and a reset in the middle of a run check that outputs hold and that the flags clear.

// File: rtl/tag_arith_pkg.sv
// Shared types for the tagged arithmetic unit.
package tag_arith_pkg;
    // Condition flag bundle, packed in N,Z,V,C order.
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } nzvc_t;
endpackage

// File: rtl/tag_check.sv
// Tag check: reports when any tag bit of either operand is set.
// Assumes the tag occupies the TAG_BITS least significant bits.
module tag_check #(
    parameter int WIDTH    = 32,
    parameter int TAG_BITS = 2
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic             tag_bad
);
    // OR-reduce the tag fields of both operands.
    always_comb begin
        tag_bad = |(opnd_a[TAG_BITS-1:0] | opnd_b[TAG_BITS-1:0]);
    end
endmodule

// File: rtl/tag_addsub_core.sv
// Combinational adder/subtractor giving the sum, the carry/borrow flag and signed overflow.
// Assumes two's complement operands; subtraction is done as a + ~b + 1.
module tag_addsub_core #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             do_sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry_flag,
    output logic             sgn_ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic             cout;

    // Form the second addend and add it with the carry-in.
    always_comb begin
        b_eff       = do_sub ? ~opnd_b : opnd_b;
        {cout, sum} = {1'b0, opnd_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, do_sub};
    end

    // Carry for add, inverted carry (borrow) for subtract; signed overflow from sign bits.
    always_comb begin
        carry_flag = do_sub ? ~cout : cout;
        sgn_ovf    = (opnd_a[MSB] == b_eff[MSB]) && (sum[MSB] != opnd_a[MSB]);
    end
endmodule

// File: rtl/tagged_arith_unit.sv
// Tagged add/subtract unit with optional trap on a tag fault or signed overflow.
// A trapping fault commits nothing: result and flags keep their old values.
// Assumes a synchronous active-low reset and at most one operation per cycle.
module tagged_arith_unit #(
    parameter int WIDTH    = 32,
    parameter int TAG_BITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             op_sub,
    input  logic             trap_en,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_v,
    output logic             flag_c,
    output logic             trap
);
    import tag_arith_pkg::*;

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] sum;
    logic             carry_flag;
    logic             sgn_ovf;
    logic             tag_bad;
    logic             fault;
    logic             do_trap;
    nzvc_t            flags_nxt;
    nzvc_t            flags_q;

    tag_addsub_core #(.WIDTH(WIDTH)) u_core (
        .opnd_a     (src_a),
        .opnd_b     (src_b),
        .do_sub     (op_sub),
        .sum        (sum),
        .carry_flag (carry_flag),
        .sgn_ovf    (sgn_ovf)
    );

    tag_check #(.WIDTH(WIDTH), .TAG_BITS(TAG_BITS)) u_tag (
        .opnd_a  (src_a),
        .opnd_b  (src_b),
        .tag_bad (tag_bad)
    );

    // Decide whether this operation traps and build its candidate flags.
    always_comb begin
        fault       = tag_bad | sgn_ovf;
        do_trap     = in_valid & trap_en & fault;
        flags_nxt.n = sum[MSB];
        flags_nxt.z = (sum == '0);
        flags_nxt.v = fault;
        flags_nxt.c = carry_flag;
    end

    // Commit result and flags only for a non-trapping operation; pulse trap otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            trap      <= 1'b0;
            result    <= '0;
            flags_q   <= '0;
        end else begin
            out_valid <= in_valid & ~do_trap;
            trap      <= do_trap;
            if (in_valid && !do_trap) begin
                result  <= sum;
                flags_q <= flags_nxt;
            end
        end
    end

    // Break out the flag bundle onto the ports.
    always_comb begin
        flag_n = flags_q.n;
        flag_z = flags_q.z;
        flag_v = flags_q.v;
        flag_c = flags_q.c;
    end
endmodule

// File: rtl/tagged_arith_unit_chk.sv
// Assertion checker for tagged_arith_unit, attached by bind.
module tagged_arith_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             trap_en,
    input logic [WIDTH-1:0] src_a,
    input logic [WIDTH-1:0] src_b,
    input logic             out_valid,
    input logic [WIDTH-1:0] result,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_v,
    input logic             flag_c,
    input logic             trap
);
    // R8: a trap and a written result never coincide.
    a_r8_trap_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap && out_valid));

    // R8: in a trap cycle nothing changed.
    a_r8_trap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> ($stable(result) && $stable({flag_n, flag_z, flag_v, flag_c})));

    // R6: a tag fault with trapping enabled always traps.
    a_r6_tag_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && trap_en && ((src_a[1:0] | src_b[1:0]) != 2'b00)) |=> trap);

    // R10: idle input gives idle outputs.
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !trap));

    // R4: zero flag agrees with a written result.
    a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (flag_z == (result == '0)));

    // R9: without trapping, every accepted operation is written.
    a_r9_no_trap_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !trap_en) |=> out_valid);
endmodule

bind tagged_arith_unit tagged_arith_unit_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_tagged_arith_unit.sv
`timescale 1ns/1ps
module sim_tagged_arith_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        op_sub;
    logic        trap_en;
    logic [31:0] src_a;
    logic [31:0] src_b;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_v, flag_c;
    logic        trap;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tagged_arith_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .trap_en(trap_en), .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .result(result), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
        .flag_c(flag_c), .trap(trap)
    );

    // Vector: op_sub, trap_en, a, b, expected result, expected NZVC, expected trap
    localparam int NV = 12;
    localparam logic [102:0] VEC [NV] = '{
        {1'b0, 1'b0, 32'h0000_0004, 32'h0000_0008, 32'h0000_000C, 4'b0000, 1'b0}, // R2 clean add
        {1'b0, 1'b0, 32'h7FFF_FFFC, 32'h0000_0004, 32'h8000_0000, 4'b1010, 1'b0}, // R7 R9 add ovf
        {1'b0, 1'b1, 32'h7FFF_FFFC, 32'h0000_0004, 32'h8000_0000, 4'b1010, 1'b1}, // R8 add ovf trap
        {1'b0, 1'b0, 32'hFFFF_FFFC, 32'h0000_0004, 32'h0000_0000, 4'b0101, 1'b0}, // R5 carry, R4 zero
        {1'b1, 1'b0, 32'h0000_0008, 32'h0000_0004, 32'h0000_0004, 4'b0000, 1'b0}, // R3 clean sub
        {1'b1, 1'b0, 32'h0000_0004, 32'h0000_0008, 32'hFFFF_FFFC, 4'b1001, 1'b0}, // R5 borrow
        {1'b1, 1'b0, 32'h8000_0000, 32'h0000_0004, 32'h7FFF_FFFC, 4'b0010, 1'b0}, // R7 sub ovf
        {1'b1, 1'b1, 32'h0000_0008, 32'h0000_0008, 32'h0000_0000, 4'b0100, 1'b0}, // R4 zero sub
        {1'b0, 1'b0, 32'h0000_0005, 32'h0000_0008, 32'h0000_000D, 4'b0010, 1'b0}, // R6 tag in a
        {1'b0, 1'b1, 32'h0000_0004, 32'h0000_000A, 32'h0000_000D, 4'b0010, 1'b1}, // R6 tag in b, trap
        {1'b1, 1'b1, 32'h7FFF_FFFC, 32'hFFFF_FFFC, 32'h0000_000D, 4'b0010, 1'b1}, // R8 sub ovf trap
        {1'b1, 1'b0, 32'h7FFF_FFFC, 32'hFFFF_FFFC, 32'h8000_0000, 4'b1011, 1'b0}  // R9 sub ovf no trap
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic s, input logic te, input logic [31:0] a, input logic [31:0] b);
        in_valid = 1'b1; op_sub = s; trap_en = te; src_a = a; src_b = b;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; op_sub = 1'b0; trap_en = 1'b0; src_a = '0; src_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 reset", {out_valid, trap, flag_n, flag_z, flag_v, flag_c, result},
              {6'b0, 32'h0});
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [102:0] v;
            v = VEC[i];
            issue(v[102], v[101], v[100:69], v[68:37]);
            check($sformatf("R2 R3 R8 vec%0d valid/trap", i), {out_valid, trap}, {~v[0], v[0]});
            check($sformatf("R2 R3 R9 vec%0d result", i), result, v[36:5]);
            check($sformatf("R4 R5 R7 vec%0d nzvc", i), {flag_n, flag_z, flag_v, flag_c}, v[4:1]);
        end

        // R8: trap is a single-cycle pulse
        issue(1'b0, 1'b1, 32'h0000_0001, 32'h0000_0000);
        check("R8 trap high", trap, 1'b1);
        @(negedge clk);
        check("R8 trap one cycle", trap, 1'b0);
        // R10: idle keeps result and flags
        check("R10 idle outputs", {out_valid, trap}, 2'b00);
        check("R10 hold result", result, 32'h8000_0000);
        check("R10 hold flags", {flag_n, flag_z, flag_v, flag_c}, 4'b1011);

        // R1: reset mid-run clears flags and result
        issue(1'b1, 1'b0, 32'h0000_0004, 32'h0000_0008);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid-run reset", {out_valid, trap, flag_n, flag_z, flag_v, flag_c, result},
              {6'b0, 32'h0});
        rst_n = 1'b1;
        // R2 after reset, simple add
        issue(1'b0, 1'b1, 32'h0000_0010, 32'h0000_0020);
        check("R2 after reset", {out_valid, result}, {1'b1, 32'h0000_0030});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule